// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block is the integer address unit that sits beside a memory port in a signal-processing datapath. For each data access it presents an address and, at the closing clock edge of that same access cycle, post-modifies its index register by a signed step. The post-modify wraps modulo a programmable buffer length, so the index walks a circular buffer and the newest sample replaces the oldest without any data being moved.

One bank of four registers is kept: index, step (modify), buffer base and buffer length. They are loaded from one shared data bus through separate load strobes. Loading the base also moves the index to the base. A length of zero turns wrapping off, and the unit then steps linearly modulo 2^AW. For FFT data reordering, a mode input mirrors the low N bits of the presented address, where N is given on a port. The index itself keeps its natural order in this mode.

Top module: `agu_top`

## Requirements
- R1: With `bitrev_en` low, `addr` equals the current `index` combinationally, in the access cycle itself.
- R2: When `access` is high and neither `ld_index` nor `ld_base` is high, `index` takes the post-modified value at the next rising edge. The post-modified value is index plus the step, with the step read as a two's-complement number of AW bits. The step used is the value held before that edge.
- R3: With a non-zero length, a post-modified value at or above base+length has the length subtracted from it. For a step whose magnitude is no more than the length, an index inside [base, base+length-1] therefore stays inside the buffer.
- R4: With a non-zero length, a post-modified value below base has the length added to it.
- R5: With a length of zero, the post-modify is linear and wraps only modulo 2^AW.
- R6: With `bitrev_en` high, bit i of `addr` (for i < N) is bit N-1-i of `index`, and bits at or above N are passed through unchanged. N is `bitrev_bits` clamped to AW. N = 0 or 1 gives `addr` equal to `index`.
- R7: `ld_base` loads `ld_data` into both the base register and the index at the next edge.
- R8: `ld_index` loads `ld_data` into the index. Either index load overrides an access step in the same cycle. `ld_modify` and `ld_length` load their registers at the next edge.
- R9: With `access`, `ld_index` and `ld_base` all low, `index` holds its value.
- R10: During reset all four registers are zero, so `index` and `addr` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_data | input | AW (16) | Shared load data for all registers |
| ld_index | input | 1 | Load index from `ld_data` |
| ld_modify | input | 1 | Load step (two's complement) from `ld_data` |
| ld_base | input | 1 | Load base and index from `ld_data` |
| ld_length | input | 1 | Load buffer length from `ld_data`; 0 disables wrapping |
| access | input | 1 | Data access strobe; post-modifies the index |
| bitrev_en | input | 1 | Mirror the low bits of `addr` |
| bitrev_bits | input | NW (5) | Number N of mirrored low bits, clamped to AW |
| addr | output | AW (16) | Address presented for the current access |
| index | output | AW (16) | Current index register (updated value after an access edge) |

## Verification
`addr` is combinational from the stored index and the mode inputs, so it is due in the same cycle its inputs are applied. An updated `index` appears one rising edge after the access or load strobe. The driver applies inputs 2 ns after a rising edge and queues the address expected in that cycle together with the index the model holds before that cycle's update. The monitor compares both at the following falling edge, so a register change is always seen exactly one cycle after its cause, and a combinational address is compared against inputs that have settled.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // Source of the next index value, in priority order.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_STEP = 2'd1,
        SRC_BASE = 2'd2,
        SRC_LOAD = 2'd3
    } idx_src_e;

    function automatic idx_src_e pick_src(input logic ld_idx, input logic ld_bse,
                                          input logic acc);
        if (ld_idx)      return SRC_LOAD;
        else if (ld_bse) return SRC_BASE;
        else if (acc)    return SRC_STEP;
        else             return SRC_HOLD;
    endfunction

endpackage

// File: rtl/agu_step.sv
module agu_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx_i,
    input  logic [AW-1:0] mod_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] nxt_o
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum_w;
    logic signed [EW-1:0] lo_w;
    logic signed [EW-1:0] hi_w;
    logic signed [EW-1:0] len_w;
    logic signed [EW-1:0] fix_w;

    always_comb begin
        sum_w = $signed({2'b00, idx_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});
        lo_w  = $signed({2'b00, base_i});
        len_w = $signed({2'b00, len_i});
        hi_w  = lo_w + len_w;
        fix_w = sum_w;
        if (len_i != '0) begin
            if (sum_w >= hi_w)      fix_w = sum_w - len_w;
            else if (sum_w < lo_w)  fix_w = sum_w + len_w;
        end
        nxt_o = fix_w[AW-1:0];
    end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
    parameter int AW = 16,
    localparam int NW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] val_i,
    input  logic          en_i,
    input  logic [NW-1:0] nbits_i,
    output logic [AW-1:0] val_o
);
    localparam logic [NW-1:0] AW_N = NW'(AW);

    logic [NW-1:0] eff_w;
    logic [AW-1:0] mir_w;

    assign eff_w = (nbits_i > AW_N) ? AW_N : nbits_i;

    for (genvar g = 0; g < AW; g++) begin : g_bit
        always_comb begin
            mir_w[g] = val_i[g];
            for (int k = g + 1; k <= AW; k++) begin
                if (eff_w == NW'(k)) mir_w[g] = val_i[k-1-g];
            end
        end
    end

    assign val_o = en_i ? mir_w : val_i;
endmodule

// File: rtl/agu_top.sv
module agu_top #(
    parameter int AW = 16,
    localparam int NW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ld_data,
    input  logic          ld_index,
    input  logic          ld_modify,
    input  logic          ld_base,
    input  logic          ld_length,
    input  logic          access,
    input  logic          bitrev_en,
    input  logic [NW-1:0] bitrev_bits,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] index
);
    import agu_pkg::*;

    typedef struct packed {
        logic [AW-1:0] idx;
        logic [AW-1:0] mod;
        logic [AW-1:0] base;
        logic [AW-1:0] len;
    } regs_t;

    regs_t    regs_q;
    regs_t    regs_d;
    idx_src_e src_w;
    logic [AW-1:0] step_w;
    logic [AW-1:0] base_w;
    logic [AW-1:0] len_w;
    logic [AW-1:0] mod_w;

    agu_step #(.AW(AW)) u_step (
        .idx_i  (regs_q.idx),
        .mod_i  (regs_q.mod),
        .base_i (regs_q.base),
        .len_i  (regs_q.len),
        .nxt_o  (step_w)
    );

    agu_bitrev #(.AW(AW)) u_rev (
        .val_i   (regs_q.idx),
        .en_i    (bitrev_en),
        .nbits_i (bitrev_bits),
        .val_o   (addr)
    );

    always_comb begin
        regs_d = regs_q;
        src_w  = pick_src(ld_index, ld_base, access);
        unique case (src_w)
            SRC_LOAD: regs_d.idx = ld_data;
            SRC_BASE: regs_d.idx = ld_data;
            SRC_STEP: regs_d.idx = step_w;
            default:  regs_d.idx = regs_q.idx;
        endcase
        if (ld_modify) regs_d.mod  = ld_data;
        if (ld_base)   regs_d.base = ld_data;
        if (ld_length) regs_d.len  = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign index  = regs_q.idx;
    assign base_w = regs_q.base;
    assign len_w  = regs_q.len;
    assign mod_w  = regs_q.mod;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
    parameter int AW = 16,
    localparam int NW = $clog2(AW + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ld_data,
    input logic          ld_index,
    input logic          ld_base,
    input logic          ld_length,
    input logic          access,
    input logic          bitrev_en,
    input logic [NW-1:0] bitrev_bits,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] index,
    input logic [AW-1:0] base_r,
    input logic [AW-1:0] len_r,
    input logic [AW-1:0] mod_r
);
    logic [AW:0]   hi_c;
    logic          in_buf_c;
    logic [AW-1:0] mag_c;
    logic          no_ld_c;

    assign hi_c     = {1'b0, base_r} + {1'b0, len_r};
    assign in_buf_c = (index >= base_r) && ({1'b0, index} < hi_c);
    assign mag_c    = mod_r[AW-1] ? (~mod_r + 1'b1) : mod_r;
    assign no_ld_c  = !ld_index && !ld_base;

    // R1: address tracks the index when mirroring is off
    a_r1_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !bitrev_en |-> addr == index);

    // R3/R4: a wrapped step keeps the index inside the buffer
    a_r3_stays_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (access && no_ld_c && !ld_length && len_r != '0 && in_buf_c && mag_c <= len_r)
        |=> in_buf_c);

    // R5: zero length gives linear stepping
    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (access && no_ld_c && len_r == '0) |=> index == $past(index + mod_r));

    // R6: zero mirrored bits leaves the address unchanged
    a_r6_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bitrev_en && bitrev_bits == '0) |-> addr == index);

    // R7: base load moves the index to the base
    a_r7_base_sets_index: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_base && !ld_index) |=> (index == $past(ld_data) && base_r == $past(ld_data)));

    // R8: index load wins over a step
    a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_index |=> index == $past(ld_data));

    // R9: idle cycles hold the index
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && no_ld_c) |=> $stable(index));
endmodule

bind agu_top agu_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_data     (ld_data),
    .ld_index    (ld_index),
    .ld_base     (ld_base),
    .ld_length   (ld_length),
    .access      (access),
    .bitrev_en   (bitrev_en),
    .bitrev_bits (bitrev_bits),
    .addr        (addr),
    .index       (index),
    .base_r      (base_w),
    .len_r       (len_w),
    .mod_r       (mod_w)
);

// File: tb/agu_top_test.sv
module agu_top_test;
    localparam int AW = 16;
    localparam int NW = $clog2(AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ld_data = '0;
    logic          ld_index = 1'b0;
    logic          ld_modify = 1'b0;
    logic          ld_base = 1'b0;
    logic          ld_length = 1'b0;
    logic          access = 1'b0;
    logic          bitrev_en = 1'b0;
    logic [NW-1:0] bitrev_bits = '0;
    logic [AW-1:0] addr;
    logic [AW-1:0] index;

    always #10 clk = ~clk;

    agu_top #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_data(ld_data), .ld_index(ld_index),
        .ld_modify(ld_modify), .ld_base(ld_base), .ld_length(ld_length),
        .access(access), .bitrev_en(bitrev_en), .bitrev_bits(bitrev_bits),
        .addr(addr), .index(index)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [AW-1:0] i;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 1'b0;

    logic [AW-1:0] m_idx = '0, m_mod = '0, m_base = '0, m_len = '0;

    function automatic logic [AW-1:0] model_rev(input logic [AW-1:0] v, input bit en,
                                                input int n);
        logic [AW-1:0] r;
        int            e;
        r = v;
        e = (n > AW) ? AW : n;
        if (en) for (int i = 0; i < e; i++) r[i] = v[e-1-i];
        return r;
    endfunction

    function automatic logic [AW-1:0] model_step();
        int s;
        s = int'(m_idx) + int'($signed(m_mod));
        if (m_len != 0) begin
            if (s >= int'(m_base) + int'(m_len)) s = s - int'(m_len);
            else if (s < int'(m_base))           s = s + int'(m_len);
        end
        return s[AW-1:0];
    endfunction

    task automatic drive(input bit li, input bit lm, input bit lb, input bit ll,
                         input bit ac, input bit br, input int nb,
                         input logic [AW-1:0] d, input string tag);
        exp_t          e;
        logic [AW-1:0] nxt;
        @(posedge clk);
        #2;
        ld_index = li; ld_modify = lm; ld_base = lb; ld_length = ll;
        access = ac; bitrev_en = br; bitrev_bits = NW'(nb); ld_data = d;
        e.a = model_rev(m_idx, br, nb);
        e.i = m_idx;
        e.tag = tag;
        q.push_back(e);
        nxt = m_idx;
        if (li || lb)  nxt = d;
        else if (ac)   nxt = model_step();
        m_idx = nxt;
        if (lm) m_mod  = d;
        if (lb) m_base = d;
        if (ll) m_len  = d;
    endtask

    task automatic acc(input bit br, input int nb, input string tag);
        drive(0, 0, 0, 0, 1, br, nb, '0, tag);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 16'hDEAD, tag);
    endtask

    // Monitor: compare at the falling edge of the cycle the item was driven in.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                if (addr !== e.a || index !== e.i) begin
                    errors++;
                    $display("FAIL %s: addr=%h index=%h expected addr=%h index=%h",
                             e.tag, addr, index, e.a, e.i);
                end
            end
        end
    end

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        ld_data = 16'hFFFF; ld_index = 1'b1; access = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (addr !== '0 || index !== '0) begin
            errors++;
            $display("FAIL R10: addr=%h index=%h expected addr=0000 index=0000", addr, index);
        end
        ld_index = 1'b0; access = 1'b0; ld_data = '0;
        @(posedge clk); #2; rst_n = 1'b1;

        // R7: base load sets base and index; R8: length and step loads
        drive(0, 0, 0, 1, 0, 0, 0, 16'd8, "R8");
        drive(0, 0, 1, 0, 0, 0, 0, 16'd100, "R7");
        drive(0, 1, 0, 0, 0, 0, 0, 16'd3, "R8");
        // R1/R2/R3: forward walk with wrap at the top
        for (int k = 0; k < 7; k++) acc(0, 0, "R3");
        idle("R2");
        // R9: idle cycles hold
        idle("R9"); idle("R9");
        // R4: negative step wraps below base
        drive(0, 1, 0, 0, 0, 0, 0, 16'hFFFD, "R8");
        for (int k = 0; k < 6; k++) acc(0, 0, "R4");
        // R3: step equal to the length returns to the same slot
        drive(0, 1, 0, 0, 0, 0, 0, 16'd8, "R8");
        acc(0, 0, "R3"); acc(0, 0, "R3");
        // R2: step uses the old value when loaded in the same cycle
        drive(0, 1, 0, 0, 1, 0, 0, 16'd1, "R2");
        acc(0, 0, "R2");
        // R8: index load overrides an access
        drive(1, 0, 0, 0, 1, 0, 0, 16'd105, "R8");
        acc(0, 0, "R8");
        // R5: zero length is linear and wraps at 2^AW
        drive(0, 0, 0, 1, 0, 0, 0, 16'd0, "R5");
        drive(0, 0, 1, 0, 0, 0, 0, 16'hFFF0, "R5");
        drive(0, 1, 0, 0, 0, 0, 0, 16'h0009, "R5");
        for (int k = 0; k < 4; k++) acc(0, 0, "R5");
        drive(0, 1, 0, 0, 0, 0, 0, 16'hFFF9, "R5");
        acc(0, 0, "R5"); acc(0, 0, "R5");
        // R6: mirrored low bits with several widths
        drive(1, 0, 0, 0, 0, 0, 0, 16'h1234, "R8");
        drive(0, 0, 0, 0, 0, 1, 4, 16'h0, "R6");
        drive(0, 0, 0, 0, 0, 1, 16, 16'h0, "R6");
        drive(0, 0, 0, 0, 0, 1, 0, 16'h0, "R6");
        drive(0, 0, 0, 0, 0, 1, 1, 16'h0, "R6");
        drive(0, 0, 0, 0, 0, 1, 20, 16'h0, "R6");
        drive(0, 0, 0, 0, 0, 1, 3, 16'h0, "R6");
        // R6: FFT-style walk of an 8-entry buffer in mirrored order
        drive(0, 0, 0, 1, 0, 0, 0, 16'd8, "R6");
        drive(0, 0, 1, 0, 0, 0, 0, 16'h0040, "R6");
        drive(0, 1, 0, 0, 0, 0, 0, 16'd1, "R6");
        for (int k = 0; k < 9; k++) acc(1, 3, "R6");
        // R1: plain address after mirroring is switched off
        acc(0, 3, "R1");
        idle("R9");
        idle("R9");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule